// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This block timestamps edges of one external input. A 32-bit counter advances once per module clock while it is allowed to run. When the input shows the edge that the current capture slot waits for, the counter value is stored in that slot's capture register. The sequencer then moves to the next slot. Each of the four slots has its own edge polarity, so one pass can measure a high time, a low time and a period without software stepping in.

Software reaches the block through a simple 32-bit register port. Writes take effect at the clock edge, and reads are combinational from the address. The counter and the capture registers can be loaded by software. A control register holds the following fields: the polarity of each slot, load and run enables, the last slot used before the sequence returns to slot 1, and a choice between continuous and single-pass operation. Every capture and every counter wrap sets a sticky flag. Enabled flags feed one global flag that drives the interrupt line.

Top module: `stamp_capture`

## Requirements
- R1: After reset the counter, all capture registers, the control register, the enables, every flag and `irq` are zero, and offset 0x5C reads the constant 0x5354_4301.
- R2: With control bit 20 set, the counter at offset 0x00 increases by one every clock. A write to 0x00 loads a new value, and counting continues from it. The capture registers at 0x08, 0x0C, 0x10 and 0x14 (slots 1 to 4) read back what software writes.
- R3: With control bit 20 clear, the counter holds its value. With control bit 8 clear, input edges load no capture register and set no flag.
- R4: After 0xFFFFFFFF the counter wraps to 0, and that step sets the overflow flag, bit 21 of offset 0x2C.
- R5: The input passes through a two-flop synchronizer. A qualifying edge stores the counter value that stood two clocks after the input changed. Slots are filled in the order 1, 2, 3, 4 and then start again at 1.
- R6: Control bit 2*i selects the edge for slot i+1: 0 means rising and 1 means falling. An edge of the other direction is ignored while that slot is armed.
- R7: Control bits 18:17 give the index of the last slot used, where 0 means slot 1 and 3 means slot 4. After capturing into that slot the sequence returns to slot 1.
- R8: With control bit 16 set, the sequencer stops after the last slot and later edges are ignored. Any write to the control register clears the stop and re-arms slot 1.
- R9: Flag bits 17 to 20 of offset 0x2C are set by captures into slots 1 to 4. Each flag stays set until a 1 is written to bit i+1 of offset 0x30. Bits written as 0 change nothing.
- R10: Bits 5:1 of offset 0x2C enable the four capture flags and the overflow flag. An event whose enable bit is set raises the global flag, which drives `irq`. Writing 1 to bit 0 of 0x30 clears the global flag, and an event whose enable bit is clear leaves `irq` low.
- R11: When an event and a software clear of the same flag fall in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; also the counter's time base |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt, high while the global flag is set |

## Verification
A wrong slot pointer shows up as a timestamp in the wrong capture register. Such a value appears three clocks after the input edge, when that register and the flag word are read. A wrong polarity choice or a wrong stop index shows up as a capture that is missing or misplaced on the next edge. A single-pass sequencer that fails to halt overwrites slot 1 on the edge after the pass ends. Flag and global-flag faults appear on `irq` and in the flag word in the clock after the event or clear. A counter off by one shows in every stamp, because the expected values are built from a counter reading plus two.

// File: rtl/stc_pkg.sv
// Package: register offsets and control-field positions shared by the
// capture unit. Assumes a 32-bit data path and byte addresses with 4-byte stride.
package stc_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_SLOTS = 4;
    localparam int NUM_EVT   = NUM_SLOTS + 1;   // captures plus overflow

    localparam logic [7:0] OFF_CNT   = 8'h00;
    localparam logic [7:0] OFF_CAP0  = 8'h08;
    localparam logic [7:0] OFF_CTRL  = 8'h28;
    localparam logic [7:0] OFF_ENFLG = 8'h2C;
    localparam logic [7:0] OFF_CLR   = 8'h30;
    localparam logic [7:0] OFF_ID    = 8'h5C;

    localparam int BIT_LOAD_EN = 8;
    localparam int BIT_ONESHOT = 16;
    localparam int STOP_LSB    = 17;
    localparam int BIT_RUN     = 20;
    localparam int EN_LSB      = 1;
    localparam int FLG_LSB     = 17;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0017_0155;
endpackage

// File: rtl/stc_edge_detect.sv
// Edge detector: synchronizes an asynchronous input through SYNC_STAGES
// flops, then reports a rising or falling edge as picked by fall_sel.
// Assumes fall_sel is already synchronous to clk.
module stc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    assign level = sync_q[SYNC_STAGES-1];

    // Shift the raw input through the synchronizer and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            prev_q <= level;
        end
    end

    // Choose the edge direction that the armed slot wants.
    always_comb begin
        hit = fall_sel ? (prev_q & ~level) : (level & ~prev_q);
    end
endmodule

// File: rtl/stc_sequencer.sv
// Slot sequencer: walks capture slots from 0 up to stop_idx, then wraps.
// In single-pass mode it halts after stop_idx until rearm. Assumes hit is a
// single-cycle pulse.
module stc_sequencer #(
    parameter int SLOTS  = 4,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              load_en,
    input  logic              oneshot,
    input  logic [SLOT_W-1:0] stop_idx,
    input  logic              rearm,
    output logic [SLOT_W-1:0] slot,
    output logic              take
);
    logic stopped_q;

    assign take = hit & load_en & ~stopped_q;

    // Advance, wrap or halt the slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            stopped_q <= 1'b0;
        end else if (rearm) begin
            slot      <= '0;
            stopped_q <= 1'b0;
        end else if (take) begin
            if (slot >= stop_idx) begin
                slot      <= '0;
                stopped_q <= oneshot;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_q && !rearm) |=> (stopped_q && $stable(slot))); // R8
    AST_WRAP_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rearm && slot >= stop_idx) |=> slot == '0); // R7
endmodule

// File: rtl/stc_flags.sv
// Flag bank: sticky event flags cleared by write-one, plus a global flag
// raised by enabled events. A new event beats a clear in the same cycle.
module stc_flags #(
    parameter int NEVT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt,
    input  logic [NEVT-1:0] en,
    input  logic [NEVT-1:0] clr_evt,
    input  logic            clr_glob,
    output logic [NEVT-1:0] flags,
    output logic            irq
);
    logic glob_q;

    assign irq = glob_q;

    // Update the sticky flags and the global flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            glob_q <= 1'b0;
        end else begin
            flags  <= (flags & ~clr_evt) | evt;
            glob_q <= (glob_q & ~clr_glob) | (|(evt & en));
        end
    end

    for (genvar g = 0; g < NEVT; g++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !clr_evt[g]) |=> flags[g]); // R9
        AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && clr_evt[g]) |=> flags[g]); // R11
    end
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (|flags)); // R10
endmodule

// File: rtl/stamp_capture.sv
// Top: timestamp counter, capture registers, control/enable registers and
// register port. Reads are combinational; writes land at the clock edge.
// Assumes the register map fixed in stc_pkg.
module stamp_capture
    import stc_pkg::*;
#(
    parameter int          CNT_W       = DATA_W,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_VALUE    = 32'h5354_4301,
    localparam int         SLOT_W      = $clog2(NUM_SLOTS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cap_in,
    output logic        irq
);
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cap_q [NUM_SLOTS];
    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] evt;
    logic [NUM_SLOTS-1:0] pol_v;
    logic [NUM_SLOTS-1:0] load_v;
    logic [SLOT_W-1:0]  slot;
    logic               hit, take, run, cnt_wr, ctrl_wr, clr_wr, ovf;

    assign run     = ctrl_q[BIT_RUN];
    assign cnt_wr  = bus_wr && bus_addr == OFF_CNT;
    assign ctrl_wr = bus_wr && bus_addr == OFF_CTRL;
    assign clr_wr  = bus_wr && bus_addr == OFF_CLR;
    assign ovf     = run && !cnt_wr && (&cnt_q);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pol
        assign pol_v[k]  = ctrl_q[2*k];
        assign load_v[k] = take && slot == SLOT_W'(k);
    end

    // Timestamp counter: software load, otherwise count while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= bus_wdata[CNT_W-1:0];
        else if (run)    cnt_q <= cnt_q + CNT_W'(1);
    end

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
            if (bus_wr && bus_addr == OFF_ENFLG) en_q <= bus_wdata[EN_LSB +: NUM_EVT];
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cap
        // Capture register k: a capture takes precedence over a software write.
        always_ff @(posedge clk) begin
            if (!rst_n)         cap_q[k] <= '0;
            else if (load_v[k]) cap_q[k] <= cnt_q;
            else if (bus_wr && bus_addr == OFF_CAP0 + 8'(4*k))
                cap_q[k] <= bus_wdata[CNT_W-1:0];
        end
    end

    stc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .fall_sel(pol_v[slot]), .hit(hit)
    );

    stc_sequencer #(.SLOTS(NUM_SLOTS)) i_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .load_en(ctrl_q[BIT_LOAD_EN]),
        .oneshot(ctrl_q[BIT_ONESHOT]), .stop_idx(ctrl_q[STOP_LSB +: SLOT_W]),
        .rearm(ctrl_wr), .slot(slot), .take(take)
    );

    assign evt = {ovf, load_v};

    stc_flags #(.NEVT(NUM_EVT)) i_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt), .en(en_q),
        .clr_evt(clr_wr ? bus_wdata[1 +: NUM_EVT] : '0),
        .clr_glob(clr_wr && bus_wdata[0]), .flags(flags), .irq(irq)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CNT:   bus_rdata = DATA_W'(cnt_q);
            OFF_CTRL:  bus_rdata = ctrl_q;
            OFF_ENFLG: begin
                bus_rdata[EN_LSB +: NUM_EVT]  = en_q;
                bus_rdata[FLG_LSB +: NUM_EVT] = flags;
            end
            OFF_ID:    bus_rdata = ID_VALUE;
            default: begin
                for (int k = 0; k < NUM_SLOTS; k++)
                    if (bus_addr == OFF_CAP0 + 8'(4*k)) bus_rdata = DATA_W'(cap_q[k]);
            end
        endcase
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_q)); // R3
    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_v)); // R5
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr && cnt_q == '1) |=> (cnt_q == '0 && flags[NUM_SLOTS])); // R4
    AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[BIT_LOAD_EN] |-> load_v == '0); // R3
endmodule

// File: tb/test_stamp_capture.sv
module test_stamp_capture;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RUN = 32'h0010_0000, LD = 32'h0000_0100, OS = 32'h0001_0000;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, cap_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;
    int errors = 0, checks = 0;
    bit finished = 0;

    stamp_capture i_stamp_capture (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] stopv(input int s);
        return 32'(s) << 17;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Read the counter, change the input, return the expected stamp, settle.
    task automatic drive(input logic lvl, output logic [31:0] stamp);
        logic [31:0] c;
        rd(8'h00, c);
        cap_in = lvl;
        stamp = c + 32'd2;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, a, s0, s1, s2, old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, v); chk("R1 counter", v, 0);
        rd(8'h28, v); chk("R1 control", v, 0);
        rd(8'h2C, v); chk("R1 flags/enables", v, 0);
        for (int k = 0; k < 4; k++) begin rd(8'(8 + 4*k), v); chk("R1 capture", v, 0); end
        chk("R1 irq", {31'b0, irq}, 0);
        rd(8'h5C, v); chk("R1 id", v, 32'h5354_4301);

        // R2 counting and loads
        wr(8'h28, RUN);
        rd(8'h00, a); @(negedge clk); rd(8'h00, v); chk("R2 step", v, a + 1);
        wr(8'h00, 32'h0000_1000); rd(8'h00, v); chk("R2 load", v, 32'h1000);
        repeat (5) @(negedge clk); rd(8'h00, v); chk("R2 count from load", v, 32'h1005);
        wr(8'h0C, 32'h0000_ABCD); rd(8'h0C, v); chk("R2 capture write", v, 32'hABCD);

        // R3 frozen counter, loads disabled
        wr(8'h28, 0); rd(8'h00, a); repeat (4) @(negedge clk);
        rd(8'h00, v); chk("R3 frozen", v, a);
        wr(8'h28, RUN);
        drive(1, s0); drive(0, s0);
        rd(8'h08, v); chk("R3 no capture", v, 0);
        rd(8'h2C, v); chk("R3 no flag", v, 0);

        // R4 wrap and overflow flag
        wr(8'h00, 32'hFFFF_FFFD);
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk("R4 wrap to zero", v, 0);
        rd(8'h2C, v); chk("R4 overflow flag", v, 32'h0020_0000);
        wr(8'h30, 32'h3F);

        // R5 four slots, continuous, all rising
        wr(8'h28, RUN | LD | stopv(3));
        for (int k = 0; k < 5; k++) begin
            drive(1, s0); drive(0, s1);
            rd(8'(8 + 4*(k % 4)), v); chk("R5 slot order", v, s0);
        end
        rd(8'h2C, v); chk("R5 all capture flags", v, 32'h001E_0000);

        // R9 clear by write-one
        wr(8'h30, 32'h4); rd(8'h2C, v); chk("R9 clear slot2 only", v, 32'h001A_0000);
        wr(8'h30, 32'h0); rd(8'h2C, v); chk("R9 zeros no effect", v, 32'h001A_0000);

        // R6 per-slot polarity
        wr(8'h30, 32'h3F);
        wr(8'h28, RUN | LD | stopv(3) | 32'h1);
        rd(8'h08, old);
        drive(1, s0);
        rd(8'h08, v); chk("R6 rising ignored on falling slot", v, old);
        rd(8'h2C, v); chk("R6 no flag", v, 0);
        drive(0, s0); rd(8'h08, v); chk("R6 falling captured", v, s0);
        drive(1, s1); rd(8'h0C, v); chk("R6 next slot rising", v, s1);

        // R7 stop index 1: slots 1,2,1
        wr(8'h28, RUN | LD | stopv(1));
        drive(0, s0);
        rd(8'h10, old);
        drive(1, s0); drive(0, a);
        drive(1, s1); drive(0, a);
        drive(1, s2); drive(0, a);
        rd(8'h08, v); chk("R7 wrap back to slot1", v, s2);
        rd(8'h0C, v); chk("R7 slot2", v, s1);
        rd(8'h10, v); chk("R7 slot3 untouched", v, old);

        // R8 single pass
        wr(8'h28, RUN | LD | OS | stopv(1));
        drive(1, s0); drive(0, a);
        drive(1, s1); drive(0, a);
        drive(1, s2); drive(0, a);
        rd(8'h08, v); chk("R8 halted after last slot", v, s0);
        rd(8'h0C, v); chk("R8 slot2 of pass", v, s1);
        wr(8'h28, RUN | LD | OS | stopv(1));
        drive(1, s2); drive(0, a);
        rd(8'h08, v); chk("R8 rearmed", v, s2);

        // R10 enable and global flag
        wr(8'h28, RUN | LD | stopv(3));
        wr(8'h30, 32'h3F);
        wr(8'h2C, 32'h2);
        rd(8'h2C, v); chk("R10 enable readback", v, 32'h2);
        chk("R10 irq idle", {31'b0, irq}, 0);
        drive(1, s0); drive(0, a);
        chk("R10 irq on enabled event", {31'b0, irq}, 1);
        wr(8'h30, 32'h1);
        chk("R10 global clear", {31'b0, irq}, 0);
        drive(1, s0); drive(0, a);
        chk("R10 masked event no irq", {31'b0, irq}, 0);
        rd(8'h2C, v); chk("R10 masked flag still set", v, 32'h0006_0002);

        // R11 capture and clear in the same cycle
        wr(8'h28, RUN | LD | stopv(3));
        wr(8'h30, 32'h3F);
        @(negedge clk);
        cap_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h2;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h2C, v); chk("R11 event wins over clear", v, 32'h0002_0002);
        wr(8'h30, 32'h2); rd(8'h2C, v); chk("R11 later clear works", v, 32'h0000_0002);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule